// File: doc/BRIEF.md
# Tag Check Fault Policy Unit

This unit sits behind the tag comparison logic of a load/store path and decides what a failed tag check turns into. Each failure arrives as a one-cycle strobe with the faulting virtual address, the access direction, whether the access ran in the unprivileged (EL0) translation regime, and whether that regime splits the address space into two ranges. The unit takes a 2-bit policy from the system control word that the caller supplies with the strobe, then acts on it.

There are four policies. Ignore does nothing. Synchronous raises a data-abort request and latches the address and direction for the exception logic. Asynchronous sets a sticky bit in a small fault status register. Mixed treats stores as asynchronous and loads as synchronous. The status bit chosen for an asynchronous fault is address bit 55 when the regime has two ranges, and bit 0 otherwise. Software clears status bits through a masked clear port. The unit never clears them by itself.

Top module: `tcf_fault_policy`

## Requirements
- R1: After reset, `sync_abort` and `async_flag` are 0, and `abort_addr`, `abort_is_store` and `async_status` are all zero.
- R2: When `fail_el0` is 1, the policy is `ctrl_word[39:38]`. Otherwise it is `ctrl_word[41:40]`. The other field has no influence.
- R3: Policy 0 (ignore): a failure produces no pulse on either output and leaves `async_status`, `abort_addr` and `abort_is_store` unchanged.
- R4: Policy 1 (synchronous): a failure strobed in cycle n drives `sync_abort` high in cycle n+1, with `abort_addr` equal to the faulting address and `abort_is_store` equal to the access direction (1 = store). `async_flag` stays low.
- R5: Policy 2 (asynchronous): a failure strobed in cycle n drives `async_flag` high in cycle n+1 and sets one bit of `async_status` from that cycle on. `sync_abort` stays low.
- R6: Policy 3 (mixed): a store failure behaves as in R5 and a load failure behaves as in R4.
- R7: The status bit index is `fail_addr[55]` when `fail_two_range` is 1, and 0 otherwise.
- R8: Status bits are sticky. A bit falls only in the cycle after `sts_clr_vld` is high with that bit set in `sts_clr_mask`. If a set and a clear of the same bit happen in one cycle, the set wins.
- R9: `sync_abort` and `async_flag` are single-cycle pulses. In a cycle following one without a fail strobe, both are low.
- R10: `abort_addr` and `abort_is_store` change only together with a `sync_abort` pulse. Asynchronous or ignored failures do not disturb them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fail_vld | input | 1 | Tag check failure strobe |
| fail_addr | input | ADDR_W (64) | Faulting virtual address |
| fail_is_store | input | 1 | 1 = store access, 0 = load |
| fail_el0 | input | 1 | Failure in an EL0 translation regime |
| fail_two_range | input | 1 | Regime has two address ranges |
| ctrl_word | input | CTRL_W (64) | System control word holding both policy fields |
| sts_clr_vld | input | 1 | Software clear of status bits |
| sts_clr_mask | input | 2 | Status bits to clear |
| sync_abort | output | 1 | Synchronous data-abort request pulse |
| abort_addr | output | ADDR_W (64) | Address of the last synchronous abort |
| abort_is_store | output | 1 | Direction of the last synchronous abort |
| async_flag | output | 1 | Pulse marking an asynchronous status update |
| async_status | output | 2 | Sticky asynchronous fault status |

## Verification
The bench builds the block with its default widths: a 64-bit address and control word and policy fields at bits 38 and 40. It sweeps every combination of policy, direction, EL0 flag, two-range flag and address bit 55. In each case the unused policy field holds the bitwise inverse of the live one, so a wrong field selection always shows up as a different action. Because the status register is only two bits wide, directed sequences can cover every set/clear overlap, including a set and a clear of the same bit in one cycle. They also confirm that the abort address survives asynchronous and ignored failures.

// File: rtl/tcf_pkg.sv
package tcf_pkg;

    typedef enum logic [1:0] {
        TCF_IGNORE = 2'd0,
        TCF_SYNC   = 2'd1,
        TCF_ASYNC  = 2'd2,
        TCF_MIXED  = 2'd3
    } tcf_mode_e;

    typedef struct packed {
        logic raise_sync;
        logic raise_async;
    } tcf_action_s;

    // Map a policy and access direction onto the action to take.
    function automatic tcf_action_s tcf_decide(tcf_mode_e mode, logic is_store);
        tcf_action_s act;
        act = '0;
        unique case (mode)
            TCF_IGNORE: act = '0;
            TCF_SYNC:   act.raise_sync = 1'b1;
            TCF_ASYNC:  act.raise_async = 1'b1;
            TCF_MIXED: begin
                act.raise_async = is_store;
                act.raise_sync  = ~is_store;
            end
            default:    act = '0;
        endcase
        return act;
    endfunction

endpackage

// File: rtl/tcf_mode_sel.sv
module tcf_mode_sel
    import tcf_pkg::*;
#(
    parameter int CTRL_W   = 64,
    parameter int EL0_LSB  = 38,
    parameter int PRIV_LSB = 40
) (
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              el0,
    output tcf_mode_e         mode
);
    logic [1:0] el0_field;
    logic [1:0] priv_field;
    logic       unused_ctrl;

    assign el0_field   = ctrl[EL0_LSB +: 2];
    assign priv_field  = ctrl[PRIV_LSB +: 2];
    assign mode        = tcf_mode_e'(el0 ? el0_field : priv_field);
    assign unused_ctrl = ^ctrl;
endmodule

// File: rtl/tcf_sync_capture.sv
module tcf_sync_capture #(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_store,
    output logic              pulse,
    output logic [ADDR_W-1:0] addr_q,
    output logic              store_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pulse   <= 1'b0;
            addr_q  <= '0;
            store_q <= 1'b0;
        end else begin
            pulse <= fire;
            if (fire) begin
                addr_q  <= addr;
                store_q <= is_store;
            end
        end
    end
endmodule

// File: rtl/tcf_status_bank.sv
module tcf_status_bank #(
    parameter int STAT_W = 2,
    localparam int IDX_W = (STAT_W > 1) ? $clog2(STAT_W) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_vld,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic              clr_vld,
    input  logic [STAT_W-1:0] clr_mask,
    output logic [STAT_W-1:0] status
);
    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
        logic set_b;
        logic clr_b;
        assign set_b = set_vld && (set_idx == IDX_W'(b));
        assign clr_b = clr_vld && clr_mask[b];
        always_ff @(posedge clk) begin
            if (rst)        status[b] <= 1'b0;
            else if (set_b) status[b] <= 1'b1;
            else if (clr_b) status[b] <= 1'b0;
        end
    end
endmodule

// File: rtl/tcf_fault_policy.sv
module tcf_fault_policy
    import tcf_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int CTRL_W   = 64,
    parameter int EL0_LSB  = 38,
    parameter int PRIV_LSB = 40,
    parameter int SEL_BIT  = 55
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fail_vld,
    input  logic [ADDR_W-1:0] fail_addr,
    input  logic              fail_is_store,
    input  logic              fail_el0,
    input  logic              fail_two_range,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              sts_clr_vld,
    input  logic [1:0]        sts_clr_mask,
    output logic              sync_abort,
    output logic [ADDR_W-1:0] abort_addr,
    output logic              abort_is_store,
    output logic              async_flag,
    output logic [1:0]        async_status
);
    localparam int STAT_W = 2;
    localparam int IDX_W  = $clog2(STAT_W);

    tcf_mode_e   mode;
    tcf_action_s act;
    logic [IDX_W-1:0] stat_idx;
    logic        fire_sync;
    logic        fire_async;

    tcf_mode_sel #(
        .CTRL_W  (CTRL_W),
        .EL0_LSB (EL0_LSB),
        .PRIV_LSB(PRIV_LSB)
    ) u_mode (
        .ctrl(ctrl_word),
        .el0 (fail_el0),
        .mode(mode)
    );

    assign act        = tcf_decide(mode, fail_is_store);
    assign fire_sync  = fail_vld && act.raise_sync;
    assign fire_async = fail_vld && act.raise_async;
    assign stat_idx   = fail_two_range ? IDX_W'(fail_addr[SEL_BIT]) : '0;

    tcf_sync_capture #(.ADDR_W(ADDR_W)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire_sync),
        .addr    (fail_addr),
        .is_store(fail_is_store),
        .pulse   (sync_abort),
        .addr_q  (abort_addr),
        .store_q (abort_is_store)
    );

    tcf_status_bank #(.STAT_W(STAT_W)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .set_vld (fire_async),
        .set_idx (stat_idx),
        .clr_vld (sts_clr_vld),
        .clr_mask(sts_clr_mask),
        .status  (async_status)
    );

    always_ff @(posedge clk) begin
        if (rst) async_flag <= 1'b0;
        else     async_flag <= fire_async;
    end
endmodule

// File: rtl/tcf_fault_policy_chk.sv
module tcf_fault_policy_chk #(
    parameter int ADDR_W   = 64,
    parameter int CTRL_W   = 64,
    parameter int EL0_LSB  = 38,
    parameter int PRIV_LSB = 40
) (
    input logic              clk,
    input logic              rst,
    input logic              fail_vld,
    input logic [ADDR_W-1:0] fail_addr,
    input logic              fail_is_store,
    input logic              fail_el0,
    input logic [CTRL_W-1:0] ctrl_word,
    input logic              sts_clr_vld,
    input logic              sync_abort,
    input logic [ADDR_W-1:0] abort_addr,
    input logic              abort_is_store,
    input logic              async_flag,
    input logic [1:0]        async_status
);
    logic [1:0] pol;
    assign pol = fail_el0 ? ctrl_word[EL0_LSB +: 2] : ctrl_word[PRIV_LSB +: 2];

    // R3
    a_r3_ignore: assert property (@(posedge clk) disable iff (rst)
        (fail_vld && pol == 2'd0) |=> (!sync_abort && !async_flag && $stable(async_status)));

    // R4
    a_r4_sync_abort: assert property (@(posedge clk) disable iff (rst)
        (fail_vld && pol == 2'd1) |=> (sync_abort && !async_flag &&
            abort_addr == $past(fail_addr) && abort_is_store == $past(fail_is_store)));

    // R5
    a_r5_async_set: assert property (@(posedge clk) disable iff (rst)
        (fail_vld && pol == 2'd2) |=> (async_flag && !sync_abort && async_status != 2'b00));

    // R6
    a_r6_mixed_store: assert property (@(posedge clk) disable iff (rst)
        (fail_vld && pol == 2'd3 && fail_is_store) |=> (async_flag && !sync_abort));
    a_r6_mixed_load: assert property (@(posedge clk) disable iff (rst)
        (fail_vld && pol == 2'd3 && !fail_is_store) |=> (sync_abort && !async_flag));

    // R8
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        !sts_clr_vld |=> (($past(async_status) & ~async_status) == 2'b00));

    // R9
    a_r9_pulse: assert property (@(posedge clk) disable iff (rst)
        !fail_vld |=> (!sync_abort && !async_flag));

    // R10
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !sync_abort |-> ($stable(abort_addr) && $stable(abort_is_store)));
endmodule

bind tcf_fault_policy tcf_fault_policy_chk #(
    .ADDR_W  (ADDR_W),
    .CTRL_W  (CTRL_W),
    .EL0_LSB (EL0_LSB),
    .PRIV_LSB(PRIV_LSB)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .fail_vld      (fail_vld),
    .fail_addr     (fail_addr),
    .fail_is_store (fail_is_store),
    .fail_el0      (fail_el0),
    .ctrl_word     (ctrl_word),
    .sts_clr_vld   (sts_clr_vld),
    .sync_abort    (sync_abort),
    .abort_addr    (abort_addr),
    .abort_is_store(abort_is_store),
    .async_flag    (async_flag),
    .async_status  (async_status)
);

// File: tb/sim_tcf_fault_policy.sv
`timescale 1ns/1ps
module sim_tcf_fault_policy;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fail_vld = 1'b0;
    logic [63:0] fail_addr = '0;
    logic        fail_is_store = 1'b0;
    logic        fail_el0 = 1'b0;
    logic        fail_two_range = 1'b0;
    logic [63:0] ctrl_word = '0;
    logic        sts_clr_vld = 1'b0;
    logic [1:0]  sts_clr_mask = '0;
    logic        sync_abort;
    logic [63:0] abort_addr;
    logic        abort_is_store;
    logic        async_flag;
    logic [1:0]  async_status;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tcf_fault_policy u0 (
        .clk(clk), .rst(rst), .fail_vld(fail_vld), .fail_addr(fail_addr),
        .fail_is_store(fail_is_store), .fail_el0(fail_el0),
        .fail_two_range(fail_two_range), .ctrl_word(ctrl_word),
        .sts_clr_vld(sts_clr_vld), .sts_clr_mask(sts_clr_mask),
        .sync_abort(sync_abort), .abort_addr(abort_addr),
        .abort_is_store(abort_is_store), .async_flag(async_flag),
        .async_status(async_status)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply inputs for one clock; returns at the following falling edge.
    task automatic step(bit vld, logic [63:0] a, bit st, bit el0, bit tr,
                        logic [63:0] cw, bit clr, logic [1:0] msk);
        fail_vld = vld; fail_addr = a; fail_is_store = st; fail_el0 = el0;
        fail_two_range = tr; ctrl_word = cw; sts_clr_vld = clr; sts_clr_mask = msk;
        @(negedge clk);
        fail_vld = 1'b0; sts_clr_vld = 1'b0;
    endtask

    function automatic logic [63:0] make_ctrl(logic [1:0] m, bit el0);
        logic [63:0] c;
        c = 64'hA5A5_5A5A_C3C3_3C3C;
        if (el0) begin c[39:38] = m;  c[41:40] = ~m; end
        else     begin c[41:40] = m;  c[39:38] = ~m; end
        return c;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        logic [63:0] last_addr;
        logic        last_st;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 sync_abort", sync_abort, 0);
        check("R1 async_flag", async_flag, 0);
        check("R1 abort_addr", abort_addr, 0);
        check("R1 abort_is_store", abort_is_store, 0);
        check("R1 async_status", async_status, 0);
        last_addr = '0;
        last_st = 1'b0;

        // Sweep: R2 R3 R4 R5 R6 R7 R9 R10
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 16; k++) begin
                bit st, el0, tr, b55;
                logic [63:0] a;
                bit exp_sync, exp_async;
                logic [1:0] exp_stat;
                st = k[0]; el0 = k[1]; tr = k[2]; b55 = k[3];
                a = 64'h9E37_79B9_7F4A_7C15 * 64'(m * 16 + k + 1);
                a[55] = b55;
                step(0, '0, 0, 0, 0, '0, 1, 2'b11);
                check("R8 clear", async_status, 0);
                step(1, a, st, el0, tr, make_ctrl(2'(m), el0), 0, 2'b00);
                exp_sync  = (m == 1) || (m == 3 && !st);
                exp_async = (m == 2) || (m == 3 && st);
                exp_stat  = 2'b00;
                if (exp_async) exp_stat[tr ? b55 : 1'b0] = 1'b1;
                if (exp_sync) begin last_addr = a; last_st = st; end
                check("R2/R4/R6 sync_abort", sync_abort, exp_sync);
                check("R2/R5/R6 async_flag", async_flag, exp_async);
                check("R3/R5/R7 async_status", async_status, exp_stat);
                check("R4/R10 abort_addr", abort_addr, last_addr);
                check("R4/R10 abort_is_store", abort_is_store, last_st);
                step(0, a, st, el0, tr, make_ctrl(2'(m), el0), 0, 2'b00);
                check("R9 sync low", sync_abort, 0);
                check("R9 async low", async_flag, 0);
                check("R8 held", async_status, exp_stat);
            end
        end

        // R8: stickiness and clear behaviour
        step(0, '0, 0, 0, 0, '0, 1, 2'b11);
        step(1, 64'h0080_0000_0000_0000, 1, 0, 1, make_ctrl(2'd2, 0), 0, 2'b00);
        step(1, 64'h0, 1, 0, 1, make_ctrl(2'd2, 0), 0, 2'b00);
        check("R8 both set", async_status, 2'b11);
        repeat (3) step(0, '0, 0, 0, 0, '0, 0, 2'b00);
        check("R8 sticky idle", async_status, 2'b11);
        step(0, '0, 0, 0, 0, '0, 1, 2'b01);
        check("R8 masked clear", async_status, 2'b10);
        step(1, 64'h0, 1, 0, 1, make_ctrl(2'd2, 0), 1, 2'b01);
        check("R8 set wins", async_status, 2'b11);
        step(1, 64'h0, 1, 0, 1, make_ctrl(2'd2, 0), 1, 2'b10);
        check("R8 set and clear other", async_status, 2'b01);

        // R10: sync then async/ignore keeps captured address
        step(1, 64'h1234_5678_9ABC_DEF0, 1, 1, 0, make_ctrl(2'd1, 1), 0, 2'b00);
        check("R4 addr", abort_addr, 64'h1234_5678_9ABC_DEF0);
        check("R4 store dir", abort_is_store, 1);
        step(1, 64'hFFFF_0000_FFFF_0000, 0, 1, 0, make_ctrl(2'd2, 1), 0, 2'b00);
        check("R10 addr after async", abort_addr, 64'h1234_5678_9ABC_DEF0);
        step(1, 64'h0F0F_0F0F_0F0F_0F0F, 0, 0, 0, make_ctrl(2'd0, 0), 0, 2'b00);
        check("R10 addr after ignore", abort_addr, 64'h1234_5678_9ABC_DEF0);
        check("R3 no pulse", {62'd0, sync_abort, async_flag}, 0);
        check("R10 dir held", abort_is_store, 1);

        // R9: back-to-back strobes pulse every cycle, then drop
        step(1, 64'h10, 0, 1, 0, make_ctrl(2'd1, 1), 0, 2'b00);
        check("R9 first", sync_abort, 1);
        step(1, 64'h20, 0, 1, 0, make_ctrl(2'd1, 1), 0, 2'b00);
        check("R9 second", sync_abort, 1);
        check("R4 second addr", abort_addr, 64'h20);
        step(0, '0, 0, 0, 0, '0, 0, 2'b00);
        check("R9 drop", sync_abort, 0);

        finish_run();
    end
endmodule